// File: doc/BRIEF.md
# Receive Byte FIFO with Control/Status Word

This block buffers received bytes between the baseband datapath and firmware. The datapath pushes one byte per cycle on a write strobe. Firmware takes bytes one at a time from a read port: the oldest byte is always visible there, and a read strobe retires it.

A single 32-bit control/status word reports the fill state. It carries empty and full flags and the live byte count. It also holds a firmware-programmed almost-full threshold, and it has a flush control that empties the FIFO in one cycle and always reads back as zero. The almost-full condition is also driven on its own output, so that an interrupt controller can mask and route it.

The storage holds 63 bytes, so the count always fits in a 6-bit field. The reset is asynchronous and active-low. Its release is synchronised inside the block, and the FIFO leaves reset two clock edges after the input rises.

Top module: `rx_byte_fifo`

## Requirements
- R1: Status bit 14 reads 1 exactly when the FIFO holds no bytes.
- R2: Status bit 13 reads 1 exactly when the FIFO holds 63 bytes.
- R3: A control write with bit 12 set empties the FIFO by the next cycle. It overrides any push or pop in the same cycle, and bit 12 always reads back 0.
- R4: Bits 11:6 are a read/write threshold that resets to 0. Every control write loads it. `almost_full` is 1 whenever the count is at or above the threshold, so with a threshold of 0 it is always 1.
- R5: Bits 5:0 report the stored byte count. Each accepted push adds one and each accepted pop removes one. Bytes leave on `rd_data` in the order they were written, including across pointer wrap.
- R6: A push while full is dropped, even if a pop happens in the same cycle. While empty, `rd_data` reads 0 and a pop leaves the count at 0.
- R7: A push and a pop together on a FIFO that is neither empty nor full leave the count unchanged.
- R8: Bits 31:15 read 0. After reset the word reads 0x0000_4000 and `almost_full` reads 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Push strobe from the datapath |
| wr_data | input | 8 | Byte to push |
| rd_en | input | 1 | Pop strobe from firmware |
| rd_data | output | 8 | Oldest stored byte, 0 when empty |
| csr_wr_en | input | 1 | Control word write strobe |
| csr_wdata | input | 32 | Control word write data |
| csr_rdata | output | 32 | Control/status word readback |
| almost_full | output | 1 | Count at or above threshold |

## Verification
The bench drives the FIFO to exactly 63 bytes and pushes once more. A design that let the extra byte in would corrupt the oldest entry, and that shows up while the FIFO is drained in order. It flushes in the same cycle as a push and a pop, and a design that gave the flush the wrong priority would keep a byte. It also reads while empty, where a design would underflow the count to 63. The threshold is tested at its top value of 63, one byte before and at the edge, and at 0. The pointers are offset before a full fill, so the fill wraps them and an off-by-one wrap would reorder the data.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int DATA_W    = 8;
  localparam int LVL_W     = 6;
  localparam int CSR_W     = 32;
  localparam int EMPTY_BIT = 14;
  localparam int FULL_BIT  = 13;
  localparam int FLUSH_BIT = 12;
  localparam int THR_LSB   = 6;
endpackage

// File: rtl/rxf_rst_sync.sv
module rxf_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/rxf_storage.sv
module rxf_storage #(
  parameter int DATA_W = 8,
  parameter int LVL_W  = 6,
  parameter int DEPTH  = 63
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] head_data
);
  localparam logic [LVL_W-1:0] LAST = LVL_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [LVL_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [LVL_W-1:0]  rd_ptr_q, rd_ptr_d;

  function automatic logic [LVL_W-1:0] bump(input logic [LVL_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
    end else begin
      if (push) wr_ptr_d = bump(wr_ptr_q);
      if (pop)  rd_ptr_d = bump(rd_ptr_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr_q] <= wr_data;
  end

  assign head_data = mem[rd_ptr_q];
endmodule

// File: rtl/rxf_level.sv
module rxf_level #(
  parameter int LVL_W = 6,
  parameter int DEPTH = 63
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  output logic [LVL_W-1:0] level,
  output logic             empty,
  output logic             full
);
  logic [LVL_W-1:0] level_q, level_d;

  always_comb begin
    level_d = level_q;
    if (flush)             level_d = '0;
    else if (push && !pop) level_d = level_q + 1'b1;
    else if (pop && !push) level_d = level_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level_q <= '0;
    else        level_q <= level_d;
  end

  assign level = level_q;
  assign empty = (level_q == '0);
  assign full  = (level_q == LVL_W'(DEPTH));
endmodule

// File: rtl/rxf_csr.sv
module rxf_csr
  import rxf_pkg::*;
#(
  parameter int LVL_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             csr_wr_en,
  input  logic [CSR_W-1:0] csr_wdata,
  input  logic [LVL_W-1:0] level,
  input  logic             empty,
  input  logic             full,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             flush,
  output logic             almost_full
);
  logic [LVL_W-1:0] thr_q, thr_d;
  logic             unused_wbits;

  assign unused_wbits = ^{csr_wdata[CSR_W-1:FLUSH_BIT+1], csr_wdata[THR_LSB-1:0]};
  assign flush        = csr_wr_en & csr_wdata[FLUSH_BIT];

  always_comb begin
    thr_d = thr_q;
    if (csr_wr_en) thr_d = csr_wdata[THR_LSB +: LVL_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) thr_q <= '0;
    else        thr_q <= thr_d;
  end

  always_comb begin
    csr_rdata                    = '0;
    csr_rdata[EMPTY_BIT]         = empty;
    csr_rdata[FULL_BIT]          = full;
    csr_rdata[THR_LSB +: LVL_W]  = thr_q;
    csr_rdata[LVL_W-1:0]         = level;
  end

  assign almost_full = (level >= thr_q);
endmodule

// File: rtl/rx_byte_fifo.sv
module rx_byte_fifo
  import rxf_pkg::*;
#(
  parameter int DW    = DATA_W,
  parameter int LW    = LVL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_data,
  input  logic             rd_en,
  output logic [DW-1:0]    rd_data,
  input  logic             csr_wr_en,
  input  logic [CSR_W-1:0] csr_wdata,
  output logic [CSR_W-1:0] csr_rdata,
  output logic             almost_full
);
  localparam int DEPTH = (1 << LW) - 1;

  logic          rst_sync_n;
  logic          push, pop, flush, empty, full;
  logic [LW-1:0] level;
  logic [DW-1:0] head_data;

  rxf_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  assign push = wr_en & ~full  & ~flush;
  assign pop  = rd_en & ~empty & ~flush;

  rxf_storage #(.DATA_W(DW), .LVL_W(LW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_sync_n), .push(push), .pop(pop), .flush(flush),
    .wr_data(wr_data), .head_data(head_data)
  );

  rxf_level #(.LVL_W(LW), .DEPTH(DEPTH)) u_level (
    .clk(clk), .rst_n(rst_sync_n), .push(push), .pop(pop), .flush(flush),
    .level(level), .empty(empty), .full(full)
  );

  rxf_csr #(.LVL_W(LW)) u_csr (
    .clk(clk), .rst_n(rst_sync_n), .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata),
    .level(level), .empty(empty), .full(full), .csr_rdata(csr_rdata),
    .flush(flush), .almost_full(almost_full)
  );

  assign rd_data = empty ? '0 : head_data;
endmodule

// File: rtl/rxf_checker.sv
module rxf_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic        rd_en,
  input logic        csr_wr_en,
  input logic [31:0] csr_wdata,
  input logic [31:0] csr_rdata,
  input logic [7:0]  rd_data,
  input logic        almost_full
);
  logic       fl, emp, ful;
  logic [5:0] lvl, thr;

  assign fl  = csr_wr_en & csr_wdata[12];
  assign emp = csr_rdata[14];
  assign ful = csr_rdata[13];
  assign lvl = csr_rdata[5:0];
  assign thr = csr_rdata[11:6];

  a_r1_empty_level: assert property (@(posedge clk) disable iff (!rst_n)
    emp == (lvl == 6'd0));
  a_r2_full_level: assert property (@(posedge clk) disable iff (!rst_n)
    ful == (lvl == 6'd63));
  a_r3_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    fl |=> emp);
  a_r4_almost_full: assert property (@(posedge clk) disable iff (!rst_n)
    almost_full == (lvl >= thr));
  a_r5_level_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl && wr_en && !rd_en && !ful) |=> (lvl == $past(lvl) + 6'd1));
  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl && ful && wr_en && !rd_en) |=> ful);
  a_r6_empty_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    emp |-> (rd_data == 8'd0));
  a_r7_level_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl && wr_en && rd_en && !emp && !ful) |=> $stable(lvl));
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_rdata[31:15] == 17'd0);
endmodule

bind rx_byte_fifo rxf_checker u_chk (
  .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_en), .rd_en(rd_en),
  .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
  .rd_data(rd_data), .almost_full(almost_full)
);

// File: tb/rx_byte_fifo_tb.sv
module rx_byte_fifo_tb_top;
  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        wr;
    logic [7:0]  wd;
    logic        rd;
    logic        cwe;
    logic [15:0] cwd;
    logic [7:0]  pre_rd;
    logic [15:0] exp_csr;
    logic        exp_af;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 1'b0, 1'b1, 16'h00C0, 8'h00, 16'h40C0, 1'b0},
    '{1'b1, 8'hA1, 1'b0, 1'b0, 16'h0000, 8'h00, 16'h00C1, 1'b0},
    '{1'b1, 8'hB2, 1'b0, 1'b0, 16'h0000, 8'hA1, 16'h00C2, 1'b0},
    '{1'b1, 8'hC3, 1'b0, 1'b0, 16'h0000, 8'hA1, 16'h00C3, 1'b1},
    '{1'b1, 8'hD4, 1'b1, 1'b0, 16'h0000, 8'hA1, 16'h00C3, 1'b1},
    '{1'b0, 8'h00, 1'b1, 1'b0, 16'h0000, 8'hB2, 16'h00C2, 1'b0},
    '{1'b1, 8'hE5, 1'b1, 1'b1, 16'h10C0, 8'hC3, 16'h40C0, 1'b0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en, rd_en, csr_wr_en, almost_full;
  logic [7:0]  wr_data, rd_data;
  logic [31:0] csr_wdata, csr_rdata;
  int          checks = 0, failures = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_byte_fifo dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en),
    .rd_data(rd_data), .csr_wr_en(csr_wr_en), .csr_wdata(csr_wdata),
    .csr_rdata(csr_rdata), .almost_full(almost_full)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic w, input logic [7:0] d, input logic r,
                     input logic cw, input logic [31:0] cd);
    wr_en = w; wr_data = d; rd_en = r; csr_wr_en = cw; csr_wdata = cd;
    @(negedge clk);
    wr_en = 0; wr_data = 0; rd_en = 0; csr_wr_en = 0; csr_wdata = 0;
  endtask

  initial begin
    rst_n = 0; wr_en = 0; wr_data = 0; rd_en = 0; csr_wr_en = 0; csr_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R8 reset word", csr_rdata, 32'h0000_4000);
    chk("R4 reset almost_full", {31'd0, almost_full}, 32'd1);
    chk("R6 reset rd_data", {24'd0, rd_data}, 32'd0);

    for (int i = 0; i < NV; i++) begin
      chk("R5 head before op", {24'd0, rd_data}, {24'd0, VECS[i].pre_rd});
      cyc(VECS[i].wr, VECS[i].wd, VECS[i].rd, VECS[i].cwe, {16'd0, VECS[i].cwd});
      chk("R3 R4 R5 R7 vector word", csr_rdata, {16'd0, VECS[i].exp_csr});
      chk("R4 vector almost_full", {31'd0, almost_full}, {31'd0, VECS[i].exp_af});
    end

    // R6: pop while empty
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 32'd0);
    chk("R6 empty pop word", csr_rdata, 32'h0000_40C0);
    chk("R6 empty pop rd_data", {24'd0, rd_data}, 32'd0);

    // threshold 63, offset pointers to force wrap
    cyc(1'b0, 8'h00, 1'b0, 1'b1, 32'h0000_0FC0);
    chk("R4 threshold readback", csr_rdata, 32'h0000_4FC0);
    cyc(1'b1, 8'h11, 1'b0, 1'b0, 32'd0);
    cyc(1'b1, 8'h22, 1'b0, 1'b0, 32'd0);
    chk("R5 offset head", {24'd0, rd_data}, 32'h11);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 32'd0);
    chk("R5 offset second", {24'd0, rd_data}, 32'h22);
    cyc(1'b0, 8'h00, 1'b1, 1'b0, 32'd0);
    for (int i = 0; i < 63; i++) begin
      if (i == 62) chk("R4 one below threshold", {31'd0, almost_full}, 32'd0);
      cyc(1'b1, 8'(i + 16), 1'b0, 1'b0, 32'd0);
    end
    chk("R2 full word", csr_rdata, 32'h0000_2FFF);
    chk("R4 at threshold", {31'd0, almost_full}, 32'd1);
    cyc(1'b1, 8'hEE, 1'b0, 1'b0, 32'd0);
    chk("R6 push while full dropped", csr_rdata, 32'h0000_2FFF);
    cyc(1'b1, 8'hEF, 1'b1, 1'b0, 32'd0);
    chk("R6 push dropped with pop", csr_rdata, 32'h0000_0FFE);
    chk("R5 head after full pop", {24'd0, rd_data}, 32'd17);
    for (int i = 1; i < 63; i++) begin
      chk("R5 drain order", {24'd0, rd_data}, 32'(i + 16));
      cyc(1'b0, 8'h00, 1'b1, 1'b0, 32'd0);
    end
    chk("R1 drained word", csr_rdata, 32'h0000_4FC0);
    chk("R6 drained rd_data", {24'd0, rd_data}, 32'd0);

    // R3: flush with content, threshold 0
    cyc(1'b1, 8'h5A, 1'b0, 1'b0, 32'd0);
    cyc(1'b1, 8'h5B, 1'b0, 1'b0, 32'd0);
    cyc(1'b1, 8'h5C, 1'b1, 1'b1, 32'h0000_1000);
    chk("R3 flush word", csr_rdata, 32'h0000_4000);
    chk("R4 threshold 0 almost_full", {31'd0, almost_full}, 32'd1);
    chk("R3 flush rd_data", {24'd0, rd_data}, 32'd0);
    cyc(1'b1, 8'h77, 1'b0, 1'b0, 32'd0);
    chk("R3 after flush head", {24'd0, rd_data}, 32'h77);
    chk("R3 after flush word", csr_rdata, 32'h0000_0001);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule